// File: doc/BRIEF.md
# I2C Bus Clock Divider Search Engine

This block works out the two cascaded divide factors that set an I2C bus clock. The two factors are a sample count and a step count. It takes a source clock frequency in kHz and a wanted bus rate in Hz. After a one-cycle start pulse, it computes the smallest total divide ratio that keeps the bus at or below the wanted rate. It then tries each sample count in turn and keeps the factor pair whose product is smallest. The chosen pair must not push the bus above the wanted rate. When the search ends, done pulses and the two factors appear minus one, ready to be loaded into a timing register.

Every division runs on a single shared bit-serial divider, one quotient bit per cycle. This keeps the area small, and the result arrives a few hundred cycles after start. Two classes of target are rejected with an error: rates above the high-speed maximum, and rates below 1 kHz. A setting that no factor pair can bring down to the wanted rate is also rejected.

Top module: `i2c_div_search`

## Requirements
- R1: After reset, done_o and err_o are 0 and both encoded outputs are 0.
- R2: A target above 3,400,000 Hz ends the run with err_o = 1 and both encoded outputs 0.
- R3: A target whose truncated kHz value (tgt_hz_i / 1000) is 0 ends the run with err_o = 1 and both encoded outputs 0.
- R4: The minimum divide ratio is ceil(floor(src_khz_i / 2) / khz). A result of 0 is raised to 1.
- R5: The step limit is 64 for targets up to 400,000 Hz and 8 for targets above that. A candidate step count above the limit is never chosen.
- R6: Sample counts 1 to 8 are tried in ascending order, each with step = ceil(ratio / sample). A candidate replaces the kept pair only if its product is strictly smaller. The scan stops at the first replacement whose product equals the ratio.
- R7: If no candidate is accepted, the pair is (8, step limit).
- R8: If floor(src_khz_i / (2 x sample x step)) exceeds the target in kHz, err_o = 1 and both encoded outputs are 0.
- R9: On success, err_o = 0, sample_enc_o = sample - 1 (3 bits) and step_enc_o = step - 1 (6 bits). The encoded outputs change only in the cycle where done_o is 1.
- R10: done_o is high for exactly one cycle per run. A start pulse while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (sampled only when idle) |
| src_khz_i | input | 32 | Source clock frequency in kHz |
| tgt_hz_i | input | 32 | Wanted bus rate in Hz |
| done_o | output | 1 | One-cycle pulse at end of a run |
| err_o | output | 1 | Run was rejected (valid with done_o, held after) |
| sample_enc_o | output | 3 | Chosen sample count minus one |
| step_enc_o | output | 6 | Chosen step count minus one |

## Verification
A fault in the divider or the ratio register shows up as a shifted factor pair at the next done pulse. An error in the kept-best register or in the compare shows up as a pair whose product is larger than the reference, or as a skipped early exit. The bench tests targets close to the 400 kHz and 3.4 MHz borders, sub-kHz targets and sources too fast to divide down, so a wrong limit choice or a missed overclock shows at the first affected run. A stuck control state shows up as a missing done pulse, caught by the per-run timeout.

// File: rtl/i2c_div_pkg.sv
package i2c_div_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLASS,
      ST_KHZ,
      ST_MIN,
      ST_CAND,
      ST_PREP,
      ST_CHK,
      ST_FIN
   } srch_state_e;
endpackage

// File: rtl/i2c_div_divider.sv
module i2c_div_divider #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] ceil_o
);
   localparam int CW = $clog2(W + 1);

   if (W < 8) begin : g_bad_w
      $error("divider width too small");
   end

   logic [W:0]   rem_q, shifted, rem_n;
   logic [W-1:0] quo_q, quo_n, den_q;
   logic [CW-1:0] cnt_q;

   always_comb begin
      shifted = {rem_q[W-1:0], quo_q[W-1]};
      if (shifted >= {1'b0, den_q}) begin
         rem_n = shifted - {1'b0, den_q};
         quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
         rem_n = shifted;
         quo_n = {quo_q[W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !busy_o) begin
            rem_q  <= '0;
            quo_q  <= num_i;
            den_q  <= den_i;
            cnt_q  <= CW'(W);
            busy_o <= 1'b1;
         end else if (busy_o) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o  = quo_q;
   assign ceil_o = quo_q + W'(rem_q != '0);

   // R4
   rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && den_q != '0) |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/i2c_div_limits.sv
module i2c_div_limits #(
   parameter int W           = 32,
   parameter int LW          = 7,
   parameter int FS_MAX_HZ   = 400000,
   parameter int HS_MAX_HZ   = 3400000,
   parameter int STEP_LIM    = 64,
   parameter int HS_STEP_LIM = 8
) (
   input  logic [W-1:0]  tgt_i,
   output logic          range_err_o,
   output logic [LW-1:0] lim_o
);
   if (FS_MAX_HZ >= HS_MAX_HZ) begin : g_bad_speed
      $error("fast-mode maximum must lie below high-speed maximum");
   end

   assign range_err_o = (tgt_i > W'(HS_MAX_HZ));

   if (STEP_LIM == HS_STEP_LIM) begin : g_one_lim
      assign lim_o = LW'(STEP_LIM);
   end else begin : g_two_lim
      assign lim_o = (tgt_i > W'(FS_MAX_HZ)) ? LW'(HS_STEP_LIM) : LW'(STEP_LIM);
   end
endmodule

// File: rtl/i2c_div_best.sv
module i2c_div_best #(
   parameter int W    = 32,
   parameter int SW1  = 4,
   parameter int LW   = 7,
   parameter int SMAX = 8
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           init_i,
   input  logic [LW-1:0]  lim_i,
   input  logic           cand_i,
   input  logic [SW1-1:0] s_i,
   input  logic [W-1:0]   step_i,
   input  logic [W-1:0]   ratio_i,
   output logic [SW1-1:0] best_s_o,
   output logic [LW-1:0]  best_step_o,
   output logic           hit_o
);
   localparam int PW = W + SW1;

   logic [PW-1:0] prod, best_prod_q;
   logic          fits, take;

   assign prod  = PW'(s_i) * PW'(step_i);
   assign fits  = (step_i <= W'(lim_i));
   assign take  = cand_i && fits && (prod < best_prod_q);
   assign hit_o = take && (prod == PW'(ratio_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         best_s_o    <= '0;
         best_step_o <= '0;
         best_prod_q <= '0;
      end else if (init_i) begin
         best_s_o    <= SW1'(SMAX);
         best_step_o <= lim_i;
         best_prod_q <= PW'(SMAX) * PW'(lim_i);
      end else if (take) begin
         best_s_o    <= s_i;
         best_step_o <= step_i[LW-1:0];
         best_prod_q <= prod;
      end
   end

   // R6
   prod_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand_i |=> (best_prod_q <= $past(best_prod_q)));
   // R5
   step_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand_i |-> (best_step_o <= lim_i));
endmodule

// File: rtl/i2c_div_search.sv
module i2c_div_search
   import i2c_div_pkg::*;
#(
   parameter int W           = 32,
   parameter int SMAX        = 8,
   parameter int STEP_LIM    = 64,
   parameter int HS_STEP_LIM = 8,
   parameter int FS_MAX_HZ   = 400000,
   parameter int HS_MAX_HZ   = 3400000,
   parameter int SEW         = $clog2(SMAX),
   parameter int TEW         = $clog2(STEP_LIM)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           start_i,
   input  logic [W-1:0]   src_khz_i,
   input  logic [W-1:0]   tgt_hz_i,
   output logic           done_o,
   output logic           err_o,
   output logic [SEW-1:0] sample_enc_o,
   output logic [TEW-1:0] step_enc_o
);
   localparam int SW1 = $clog2(SMAX + 1);
   localparam int LW  = $clog2(STEP_LIM + 1);

   if (HS_STEP_LIM > STEP_LIM || SMAX < 2) begin : g_bad_cfg
      $error("step or sample limits out of range");
   end

   srch_state_e    state_q;
   logic [W-1:0]   src_q, tgt_q, khz_q, ratio_q, ratio_n;
   logic [SW1-1:0] s_q;
   logic           err_q, best_init_q;
   logic           dv_go_q, dv_busy, dv_done;
   logic [W-1:0]   dv_num_q, dv_den_q, dv_quo, dv_ceil, chk_den;
   logic           range_err, cand_hit;
   logic [LW-1:0]  lim;
   logic [SW1-1:0] best_s, best_s_m1;
   logic [LW-1:0]  best_step, best_step_m1;

   i2c_div_divider #(.W(W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (dv_go_q),
      .num_i   (dv_num_q),
      .den_i   (dv_den_q),
      .busy_o  (dv_busy),
      .done_o  (dv_done),
      .quo_o   (dv_quo),
      .ceil_o  (dv_ceil)
   );

   i2c_div_limits #(
      .W(W), .LW(LW), .FS_MAX_HZ(FS_MAX_HZ), .HS_MAX_HZ(HS_MAX_HZ),
      .STEP_LIM(STEP_LIM), .HS_STEP_LIM(HS_STEP_LIM)
   ) u_lim (
      .tgt_i       (tgt_q),
      .range_err_o (range_err),
      .lim_o       (lim)
   );

   i2c_div_best #(.W(W), .SW1(SW1), .LW(LW), .SMAX(SMAX)) u_best (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .init_i      (best_init_q),
      .lim_i       (lim),
      .cand_i      (state_q == ST_CAND && dv_done),
      .s_i         (s_q),
      .step_i      (dv_ceil),
      .ratio_i     (ratio_q),
      .best_s_o    (best_s),
      .best_step_o (best_step),
      .hit_o       (cand_hit)
   );

   assign ratio_n      = (dv_ceil == '0) ? W'(1) : dv_ceil;
   assign chk_den      = (W'(best_s) * W'(best_step)) << 1;
   assign best_s_m1    = best_s - 1'b1;
   assign best_step_m1 = best_step - 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         src_q        <= '0;
         tgt_q        <= '0;
         khz_q        <= '0;
         ratio_q      <= '0;
         s_q          <= '0;
         err_q        <= 1'b0;
         best_init_q  <= 1'b0;
         dv_go_q      <= 1'b0;
         dv_num_q     <= '0;
         dv_den_q     <= '0;
         done_o       <= 1'b0;
         err_o        <= 1'b0;
         sample_enc_o <= '0;
         step_enc_o   <= '0;
      end else begin
         dv_go_q     <= 1'b0;
         best_init_q <= 1'b0;
         done_o      <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               src_q   <= src_khz_i;
               tgt_q   <= tgt_hz_i;
               err_q   <= 1'b0;
               state_q <= ST_CLASS;
            end
            ST_CLASS: if (range_err) begin
               err_q   <= 1'b1;
               state_q <= ST_FIN;
            end else begin
               dv_go_q  <= 1'b1;
               dv_num_q <= tgt_q;
               dv_den_q <= W'(1000);
               state_q  <= ST_KHZ;
            end
            ST_KHZ: if (dv_done) begin
               if (dv_quo == '0) begin
                  err_q   <= 1'b1;
                  state_q <= ST_FIN;
               end else begin
                  khz_q    <= dv_quo;
                  dv_go_q  <= 1'b1;
                  dv_num_q <= src_q >> 1;
                  dv_den_q <= dv_quo;
                  state_q  <= ST_MIN;
               end
            end
            ST_MIN: if (dv_done) begin
               ratio_q     <= ratio_n;
               s_q         <= SW1'(1);
               best_init_q <= 1'b1;
               dv_go_q     <= 1'b1;
               dv_num_q    <= ratio_n;
               dv_den_q    <= W'(1);
               state_q     <= ST_CAND;
            end
            ST_CAND: if (dv_done) begin
               if (cand_hit || s_q == SW1'(SMAX)) begin
                  state_q <= ST_PREP;
               end else begin
                  s_q      <= s_q + 1'b1;
                  dv_go_q  <= 1'b1;
                  dv_num_q <= ratio_q;
                  dv_den_q <= W'(s_q) + W'(1);
               end
            end
            ST_PREP: begin
               dv_go_q  <= 1'b1;
               dv_num_q <= src_q;
               dv_den_q <= chk_den;
               state_q  <= ST_CHK;
            end
            ST_CHK: if (dv_done) begin
               if (dv_quo > khz_q) err_q <= 1'b1;
               state_q <= ST_FIN;
            end
            ST_FIN: begin
               done_o       <= 1'b1;
               err_o        <= err_q;
               sample_enc_o <= err_q ? '0 : best_s_m1[SEW-1:0];
               step_enc_o   <= err_q ? '0 : best_step_m1[TEW-1:0];
               state_q      <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R10
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   // R9
   enc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(sample_enc_o) || !$stable(step_enc_o)) |-> done_o);
   // R8
   err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && err_o) |-> (sample_enc_o == '0 && step_enc_o == '0));
   // R10
   div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE) |-> !dv_busy);
endmodule

// File: tb/i2c_div_search_bench.sv
module i2c_div_search_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] src = '0;
   logic [31:0] tgt = '0;
   logic        done, err;
   logic [2:0]  s_enc;
   logic [5:0]  t_enc;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_div_search u_i2c_div_search (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .src_khz_i(src), .tgt_hz_i(tgt),
      .done_o(done), .err_o(err),
      .sample_enc_o(s_enc), .step_enc_o(t_enc)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model(input longint s_khz, input longint t_hz,
                                 output bit e, output int se, output int te);
      longint khz, ratio, lim, best, bs, bt, st, clk_out;
      e = 0; se = 0; te = 0;
      if (t_hz > 3400000) begin e = 1; return; end
      khz = t_hz / 1000;
      if (khz == 0) begin e = 1; return; end
      lim = (t_hz > 400000) ? 8 : 64;
      ratio = ((s_khz / 2) + khz - 1) / khz;
      if (ratio == 0) ratio = 1;
      best = 8 * lim; bs = 8; bt = lim;
      for (int s = 1; s <= 8; s++) begin
         st = (ratio + s - 1) / s;
         if (st > lim) continue;
         if (s * st < best) begin
            best = s * st; bs = s; bt = st;
            if (best == ratio) break;
         end
      end
      clk_out = s_khz / (2 * bs * bt);
      if (clk_out > khz) begin e = 1; return; end
      se = int'(bs - 1); te = int'(bt - 1);
   endfunction

   task automatic run(input logic [31:0] s_khz, input logic [31:0] t_hz, input string req);
      bit e; int se, te; int waited;
      model(s_khz, t_hz, e, se, te);
      @(negedge clk);
      src = s_khz; tgt = t_hz; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waited = 0;
      while (!done && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      if (!done) begin
         check({req, " R10 timeout"}, 0, 1);
         return;
      end
      check({req, " err"}, err, e);
      check({req, " sample"}, s_enc, se);
      check({req, " step"}, t_enc, te);
      @(negedge clk);
      check("R10 done one cycle", done, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      check("watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 done", done, 0);
      check("R1 err", err, 0);
      check("R1 sample", s_enc, 0);
      check("R1 step", t_enc, 0);
      rst_n = 1'b1;

      run(32'd26000, 32'd100000, "R6 early exit");      // expect (5,26)
      check("R6 known sample", s_enc, 4);
      check("R6 known step", t_enc, 25);
      run(32'd26000, 32'd3400001, "R2 above hs");
      run(32'd26000, 32'd3400000, "R5 hs edge");
      run(32'd26000, 32'd400000, "R5 fs edge");
      run(32'd26000, 32'd400001, "R5 hs lim");
      run(32'd26000, 32'd999, "R3 sub khz");
      run(32'd1, 32'd100000, "R4 ratio floor");
      run(32'd0, 32'd1000, "R4 zero src");
      run(32'd2000000, 32'd100000, "R7 R8 overclock");
      run(32'd1025, 32'd1000, "R7 default pair");
      run(32'd66000, 32'd1000000, "R8 hs search");
      run(32'd13000, 32'd100000, "R9 encode");

      // R10 start ignored while busy
      @(negedge clk);
      src = 32'd26000; tgt = 32'd100000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      src = 32'd2000000; tgt = 32'd3500000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      check("R10 busy start err", err, 0);
      check("R10 busy start sample", s_enc, 4);
      check("R10 busy start step", t_enc, 25);
      @(negedge clk);

      for (int i = 0; i < 80; i++) begin
         logic [31:0] rs, rt;
         rs = 32'd1 + ($urandom % 700000);
         case ($urandom % 5)
            0: rt = $urandom % 1500;
            1: rt = 32'd1000 + ($urandom % 399001);
            2: rt = 32'd400001 + ($urandom % 3000000);
            3: rt = 32'd3400000 + ($urandom % 3);
            default: rt = 32'd90000 + ($urandom % 20000);
         endcase
         run(rs, rt, "R6 random");
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule